// File: doc/BRIEF.md
# SPI Register File with Flag Sequencing

This block holds the registers a processor sees for a byte-wide SPI peripheral. There are three of them: a control byte, a status-and-rate byte and a data window. They sit on a simple single-cycle read/write bus. The shift engines connect through byte strobes:

- A receive strobe delivers each completed byte.
- A take strobe reports that the transmit holding byte has moved into the shifter.

The configuration fields are brought out as plain levels for the engines to use.

The status flags carry the handshake between software and the serial side:

- Receive-full is cleared only by a status read followed by a data read. A one-bit arm records that the status was seen.
- Overrun marks a byte that arrived while the previous one was still unread. The old byte stays in place.
- Transmit-empty falls on a data write and rises again when the shifter takes the byte.
- Mode fault flags a low slave-select input while the block is an enabled master. A write to the status byte clears it.

Two requests, receive and transmit, are each gated by their enable. A select bit steers both of them either to the CPU interrupt pins or to the DMA request pins.

Addresses are 0 for control, 1 for status and 2 for data. Address 3 reads as zero.

Top module: `spi_regfile`

## Requirements
- R1: After reset, the control byte reads 0x08 and the status byte reads 0x08 (transmit-empty set, every other flag clear, rate 0). All four request outputs are low.
- R2: A write to address 0 stores the whole control byte, and it reads back unchanged. The bits have these roles: bit 7 receive request enable, bit 6 DMA select, bit 5 master, bit 4 clock polarity, bit 3 clock phase, bit 2 wired-OR output mode, bit 1 enable, bit 0 transmit request enable. Bits 5, 4, 3, 2 and 1 drive cfg_master, cfg_cpol, cfg_cpha, cfg_wired_or and cfg_enable.
- R3: The status byte has this layout: bit 7 receive-full, bit 5 overrun, bit 4 mode fault, bit 3 transmit-empty, bits 1:0 rate select. Bits 6 and 2 read 0. A write to address 1 changes only the rate bits (driving cfg_rate) and clears mode fault. It leaves the other flags as they were.
- R4: A receive strobe while receive-full is clear stores the strobed byte and sets receive-full. The byte reads at address 2 from the next cycle.
- R5: A data read clears receive-full only if a status read made while receive-full was set came before it. A data read without that status read leaves receive-full set.
- R6: A receive strobe while receive-full is set and not being cleared sets overrun and discards the new byte, so the data register keeps its old contents. Any data read clears overrun.
- R7: A write to address 2 loads tx_byte and clears transmit-empty. A tx_take strobe sets transmit-empty again.
- R8: When cfg_master and cfg_enable are both 1, a low on ss_n sets mode fault after the synchronizer stages (three edges with the default). In slave mode, a low ss_n has no effect.
- R9: The receive request is receive-full AND its enable. The transmit request is transmit-empty AND its enable. With DMA select 0 the requests drive irq_rx and irq_tx; with DMA select 1 they drive dma_rx and dma_tx. A request never appears on both of its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rx_done | input | 1 | Receive engine byte-complete strobe |
| rx_byte | input | 8 | Byte delivered with rx_done |
| tx_take | input | 1 | Shifter has taken the holding byte |
| tx_byte | output | 8 | Transmit holding byte |
| ss_n | input | 1 | Slave-select pin level |
| cfg_master | output | 1 | Master mode |
| cfg_cpol | output | 1 | Clock idle level |
| cfg_cpha | output | 1 | Clock phase |
| cfg_wired_or | output | 1 | Open-drain output mode |
| cfg_enable | output | 1 | Peripheral enable |
| cfg_rate | output | 2 | Master rate select |
| irq_rx | output | 1 | Receive CPU interrupt |
| irq_tx | output | 1 | Transmit CPU interrupt |
| dma_rx | output | 1 | Receive DMA request |
| dma_tx | output | 1 | Transmit DMA request |

## Verification
Every register and flag changes on the edge that captures the access or strobe, and read data follows the address within the same cycle. The requests follow the flags and enables with no added delay. Mode fault is the exception: it lands on the third edge after ss_n falls. The bench drives each access for exactly one edge and samples one time unit after that edge, so each check sees the state that the edge produced. The mode-fault checks wait four edges before looking.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_STAT = 1;
   localparam int unsigned REG_DATA = 2;

   localparam int unsigned ST_RXF  = 7;
   localparam int unsigned ST_OVR  = 5;
   localparam int unsigned ST_MODF = 4;
   localparam int unsigned ST_TXE  = 3;

   typedef struct packed {
      logic rx_ie;
      logic dma_sel;
      logic master;
      logic cpol;
      logic cpha;
      logic wired_or;
      logic enable;
      logic tx_ie;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = 8'h08;
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
   import spi_regfile_pkg::*;
#(
   parameter int unsigned RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              stat_we,
   input  logic [BYTE_W-1:0] wdata,
   output ctrl_t             ctrl_q,
   output logic [RATE_W-1:0] rate_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (ctrl_we) begin
         ctrl_q <= ctrl_t'(wdata);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
      end else if (stat_we) begin
         rate_q <= wdata[RATE_W-1:0];
      end
   end
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_done,
   input  logic [W-1:0] rx_byte,
   input  logic         stat_rd,
   input  logic         data_rd,
   output logic [W-1:0] rx_data,
   output logic         rx_full,
   output logic         rx_ovr
);
   logic armed;
   logic clear_full;
   logic accept;

   assign clear_full = data_rd & armed;
   assign accept     = rx_done & (~rx_full | clear_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         rx_ovr  <= 1'b0;
         armed   <= 1'b0;
      end else begin
         if (clear_full) begin
            rx_full <= 1'b0;
            armed   <= 1'b0;
         end else if (stat_rd && rx_full) begin
            armed <= 1'b1;
         end
         if (data_rd) begin
            rx_ovr <= 1'b0;
         end
         if (rx_done) begin
            if (accept) begin
               rx_full <= 1'b1;
            end else begin
               rx_ovr <= 1'b1;
            end
         end
      end
   end

   // Data storage keeps no reset value.
   always_ff @(posedge clk) begin
      if (accept) begin
         rx_data <= rx_byte;
      end
   end
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_wr,
   input  logic [W-1:0] wdata,
   input  logic         tx_take,
   output logic [W-1:0] tx_hold,
   output logic         tx_empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_empty <= 1'b1;
      end else if (data_wr) begin
         tx_empty <= 1'b0;
      end else if (tx_take) begin
         tx_empty <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (data_wr) begin
         tx_hold <= wdata;
      end
   end
endmodule

// File: rtl/spi_fault_det.sv
module spi_fault_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_n,
   input  logic watch,
   input  logic clear,
   output logic fault
);
   logic ss_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ss_s = ss_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stages;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stages <= '1;
            end else if (SYNC_STAGES == 1) begin
               stages <= ss_n;
            end else begin
               stages <= {stages[SYNC_STAGES-2:0], ss_n};
            end
         end
         assign ss_s = stages[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault <= 1'b0;
      end else if (watch && !ss_s) begin
         fault <= 1'b1;
      end else if (clear) begin
         fault <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
   import spi_regfile_pkg::*;
#(
   parameter int unsigned ADDR_W         = 2,
   parameter int unsigned RATE_W         = 2,
   parameter int unsigned SS_SYNC_STAGES = 2,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              rx_done,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              tx_take,
   output logic [BYTE_W-1:0] tx_byte,
   input  logic              ss_n,
   output logic              cfg_master,
   output logic              cfg_cpol,
   output logic              cfg_cpha,
   output logic              cfg_wired_or,
   output logic              cfg_enable,
   output logic [RATE_W-1:0] cfg_rate,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              dma_rx,
   output logic              dma_tx
);
   localparam int unsigned GAP_LO = ST_TXE - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("spi_regfile: ADDR_W must be at least 2");
      end
      if (RATE_W < 1 || RATE_W > GAP_LO) begin : g_bad_rate
         $error("spi_regfile: RATE_W must be 1 or 2");
      end
      if (SS_SYNC_STAGES > 4) begin : g_bad_sync
         $error("spi_regfile: SS_SYNC_STAGES above 4");
      end
   endgenerate

   logic  hit_ctrl, hit_stat, hit_data;
   logic  ctrl_we, stat_we, stat_rd, data_rd, data_wr;
   ctrl_t ctrl_q;
   logic  [BYTE_W-1:0] rx_data;
   logic  rx_full, rx_ovr, tx_empty, modf;
   logic  [BYTE_W-1:0] stat_byte;
   logic  rx_req, tx_req;

   assign hit_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
   assign hit_stat = (bus_addr == ADDR_W'(REG_STAT));
   assign hit_data = (bus_addr == ADDR_W'(REG_DATA));

   assign ctrl_we = bus_sel &  bus_wr & hit_ctrl;
   assign stat_we = bus_sel &  bus_wr & hit_stat;
   assign data_wr = bus_sel &  bus_wr & hit_data;
   assign stat_rd = bus_sel & ~bus_wr & hit_stat;
   assign data_rd = bus_sel & ~bus_wr & hit_data;

   spi_ctrl_reg #(.RATE_W(RATE_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (ctrl_we),
      .stat_we (stat_we),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_q),
      .rate_q  (cfg_rate)
   );

   spi_rx_path #(.W(BYTE_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_done (rx_done),
      .rx_byte (rx_byte),
      .stat_rd (stat_rd),
      .data_rd (data_rd),
      .rx_data (rx_data),
      .rx_full (rx_full),
      .rx_ovr  (rx_ovr)
   );

   spi_tx_path #(.W(BYTE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (data_wr),
      .wdata    (bus_wdata),
      .tx_take  (tx_take),
      .tx_hold  (tx_byte),
      .tx_empty (tx_empty)
   );

   spi_fault_det #(.SYNC_STAGES(SS_SYNC_STAGES)) u_fault (
      .clk   (clk),
      .rst_n (rst_n),
      .ss_n  (ss_n),
      .watch (ctrl_q.master & ctrl_q.enable),
      .clear (stat_we),
      .fault (modf)
   );

   assign cfg_master   = ctrl_q.master;
   assign cfg_cpol     = ctrl_q.cpol;
   assign cfg_cpha     = ctrl_q.cpha;
   assign cfg_wired_or = ctrl_q.wired_or;
   assign cfg_enable   = ctrl_q.enable;

   always_comb begin
      stat_byte           = '0;
      stat_byte[ST_RXF]   = rx_full;
      stat_byte[ST_OVR]   = rx_ovr;
      stat_byte[ST_MODF]  = modf;
      stat_byte[ST_TXE]   = tx_empty;
      stat_byte[RATE_W-1:0] = cfg_rate;
   end

   always_comb begin
      if (hit_ctrl)      bus_rdata = ctrl_q;
      else if (hit_stat) bus_rdata = stat_byte;
      else if (hit_data) bus_rdata = rx_data;
      else               bus_rdata = '0;
   end

   assign rx_req = rx_full  & ctrl_q.rx_ie;
   assign tx_req = tx_empty & ctrl_q.tx_ie;

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               {irq_rx, irq_tx, dma_rx, dma_tx} <= '0;
            end else begin
               irq_rx <= rx_req & ~ctrl_q.dma_sel;
               irq_tx <= tx_req & ~ctrl_q.dma_sel;
               dma_rx <= rx_req &  ctrl_q.dma_sel;
               dma_tx <= tx_req &  ctrl_q.dma_sel;
            end
         end
      end else begin : g_irq_comb
         assign irq_rx = rx_req & ~ctrl_q.dma_sel;
         assign irq_tx = tx_req & ~ctrl_q.dma_sel;
         assign dma_rx = rx_req &  ctrl_q.dma_sel;
         assign dma_tx = tx_req &  ctrl_q.dma_sel;
      end
   endgenerate
endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       data_rd,
   input logic       data_wr,
   input logic       rx_done,
   input logic       rx_full,
   input logic       rx_ovr,
   input logic       tx_empty,
   input logic       modf,
   input logic [7:0] rx_data,
   input logic       cfg_master,
   input logic       cfg_enable,
   input logic       irq_rx,
   input logic       irq_tx,
   input logic       dma_rx,
   input logic       dma_tx
);
   a_r5_full_clears_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(data_rd));

   a_r6_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> $past(rx_done && rx_full));

   a_r6_old_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full && !data_rd) |=> $stable(rx_data));

   a_r7_write_empties: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !tx_empty);

   a_r8_fault_only_master: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(modf) |-> $past(cfg_master && cfg_enable));

   a_r9_rx_one_path: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_rx, dma_rx}));

   a_r9_tx_one_path: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_tx, dma_tx}));
endmodule

bind spi_regfile spi_regfile_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .data_rd    (data_rd),
   .data_wr    (data_wr),
   .rx_done    (rx_done),
   .rx_full    (rx_full),
   .rx_ovr     (rx_ovr),
   .tx_empty   (tx_empty),
   .modf       (modf),
   .rx_data    (rx_data),
   .cfg_master (cfg_master),
   .cfg_enable (cfg_enable),
   .irq_rx     (irq_rx),
   .irq_tx     (irq_tx),
   .dma_rx     (dma_rx),
   .dma_tx     (dma_tx)
);

// File: tb/spi_regfile_bench.sv
`timescale 1ns/1ps
module spi_regfile_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       rx_done = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       tx_take = 1'b0;
   logic [7:0] tx_byte;
   logic       ss_n = 1'b1;
   logic       cfg_master, cfg_cpol, cfg_cpha, cfg_wired_or, cfg_enable;
   logic [1:0] cfg_rate;
   logic       irq_rx, irq_tx, dma_rx, dma_tx;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   spi_regfile u_spi_regfile (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_done(rx_done), .rx_byte(rx_byte), .tx_take(tx_take), .tx_byte(tx_byte),
      .ss_n(ss_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_wired_or(cfg_wired_or), .cfg_enable(cfg_enable), .cfg_rate(cfg_rate),
      .irq_rx(irq_rx), .irq_tx(irq_tx), .dma_rx(dma_rx), .dma_tx(dma_tx)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic rx_strobe(input logic [7:0] b);
      @(negedge clk);
      rx_done = 1'b1; rx_byte = b;
      @(posedge clk); #1;
      rx_done = 1'b0;
   endtask

   task automatic take_pulse();
      @(negedge clk);
      tx_take = 1'b1;
      @(posedge clk); #1;
      tx_take = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd0, v); check("R1 ctrl", v, 8'h08);
      rd(2'd1, v); check("R1 status", v, 8'h08);
      check("R1 requests", {4'h0, irq_rx, irq_tx, dma_rx, dma_tx}, 8'h00);
   endtask

   task automatic t_ctrl();
      logic [7:0] v;
      wr(2'd0, 8'h74);
      rd(2'd0, v); check("R2 readback", v, 8'h74);
      check("R2 cfg pins", {3'b0, cfg_master, cfg_cpol, cfg_cpha, cfg_wired_or, cfg_enable},
            8'b0001_1010);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_stat_write();
      logic [7:0] v;
      wr(2'd1, 8'hFF);
      rd(2'd1, v); check("R3 only rate writable", v, 8'h0B);
      check("R3 rate pins", {6'b0, cfg_rate}, 8'h03);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_rx();
      logic [7:0] v;
      rx_strobe(8'hA5);
      rd(2'd2, v); check("R4 data", v, 8'hA5);
      rd(2'd1, v); check("R5 data read alone keeps full", v & 8'h80, 8'h80);
      rd(2'd2, v);
      rd(2'd1, v); check("R5 sequence clears full", v & 8'h80, 8'h00);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      rx_strobe(8'h3C);
      rx_strobe(8'hC3);
      rd(2'd1, v); check("R6 overrun set", v & 8'hA0, 8'hA0);
      rd(2'd2, v); check("R6 old byte kept", v, 8'h3C);
      rd(2'd1, v); check("R6 overrun cleared", v & 8'hA0, 8'h00);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      wr(2'd2, 8'h5A);
      check("R7 tx byte", tx_byte, 8'h5A);
      rd(2'd1, v); check("R7 empty cleared", v & 8'h08, 8'h00);
      take_pulse();
      rd(2'd1, v); check("R7 empty set on take", v & 8'h08, 8'h08);
   endtask

   task automatic t_modf();
      logic [7:0] v;
      wr(2'd0, 8'h22);
      ss_n = 1'b0;
      repeat (4) @(posedge clk); #1;
      rd(2'd1, v); check("R8 fault set", v & 8'h10, 8'h10);
      ss_n = 1'b1;
      repeat (3) @(posedge clk); #1;
      wr(2'd1, 8'h02);
      rd(2'd1, v); check("R3 status write clears fault", v & 8'h13, 8'h02);
      wr(2'd0, 8'h02);
      ss_n = 1'b0;
      repeat (5) @(posedge clk); #1;
      rd(2'd1, v); check("R8 no fault as slave", v & 8'h10, 8'h00);
      ss_n = 1'b1;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(2'd0, 8'h81);
      check("R9 tx irq only", {4'h0, irq_rx, irq_tx, dma_rx, dma_tx}, 8'h04);
      rx_strobe(8'h11);
      check("R9 rx and tx irq", {4'h0, irq_rx, irq_tx, dma_rx, dma_tx}, 8'h0C);
      wr(2'd0, 8'hC1);
      check("R9 steered to dma", {4'h0, irq_rx, irq_tx, dma_rx, dma_tx}, 8'h03);
      wr(2'd0, 8'h40);
      check("R9 enables gate", {4'h0, irq_rx, irq_tx, dma_rx, dma_tx}, 8'h00);
      rd(2'd1, v);
      rd(2'd2, v);
      wr(2'd0, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_stat_write();
      t_rx();
      t_overrun();
      t_tx();
      t_modf();
      t_irq();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule